// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block is the device side of a 16-bit parallel NOR flash that takes commands as short sequences of bus writes. Each write carries a word address and a data byte. Two unlock writes at fixed addresses come first, then a command byte, then any argument writes. The sequencer drives a small internal storage array. Its supported operations are word program, sector erase, chip erase, an identification read, entry into the capability query table, and a faster bypass mode in which the unlock pair is dropped.

A read-mode select output tells the read path which source the next read returns: array data, identification words, progress status or query-table bytes. A busy output is high while a program or erase runs. Reads are registered: the data requested with `re` appears on `rdata` after the next rising clock edge.

The storage holds `NSEC` sectors of `SEC_WORDS` words. Command addresses are decoded on the low 11 bits of the word address, so the unlock addresses compare the same way in every sector. The array index and the sector number are taken from the low address bits.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, `rd_mode` is 0, `busy` is 0, bypass is off, and every array word reads 0xFFFF.
- R2: An unlock pair is data 0xAA at word address 0x555 followed by data 0x55 at 0x2AA, with addresses compared on bits [10:0]. A write that does not match the expected cycle returns the block to read-array mode, and the rest of that sequence has no effect.
- R3: After an unlock pair, a write at 0x555 selects the command: 0x80 erase setup, 0x90 identification, 0xA0 program, 0x20 enter bypass. Any other byte, or any other address, returns the block to read-array mode.
- R4: After 0xA0, the next write ANDs its 16-bit data into the addressed word, so stored bits only change from 1 to 0. `busy` then stays high for `PROG_CYCLES` clock cycles.
- R5: After 0x80, a second unlock pair followed by data 0x30 at any address erases, one word per cycle, the `SEC_WORDS`-aligned sector that holds the address. Erased words become 0xFFFF. Other sectors are unchanged, and status bit 7 reads 0 during the erase.
- R6: After 0x80 and a second unlock pair, data 0x10 at 0x555 sets every word of the array to 0xFFFF.
- R7: In bypass mode the command cycle needs no unlock pair and no address check. After a program finishes, the block returns to the bypass command cycle. Data 0x00 written in bypass identification mode leaves bypass.
- R8: Data 0xF0 at any address returns the block to read-array mode and clears bypass. During the data write of a program, 0xF0 is instead taken as program data.
- R9: In identification mode (`rd_mode`=1), a read at word offset (address bits [7:0]) 0 returns `MFR_ID`, offset 1 returns `DEV_ID`, and offset 2 returns 0. Any other offset returns array data.
- R10: Data 0x98 at word address 0x055 enters query mode (`rd_mode`=3) from read-array or identification mode. The table bytes read in the low byte include 0x10..0x13 = 0x51, 0x52, 0x59, 0x02; 0x27 = log2 of the array size in bytes; 0x2D = `NSEC`-1; 0x2F = sector bytes / 256. Offsets outside the table read 0. Any write leaves query mode.
- R11: While `busy` is high, `rd_mode` is 2 and all writes are ignored. A status read returns bit 7 (the inverted bit 7 of the program data, or 0 for an erase) and bit 6, which inverts on every status read. All other bits read 0.
- R12: `rdata` changes only on the rising edge at which `re` is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| we | input | 1 | Bus write strobe, one cycle per write |
| re | input | 1 | Bus read strobe |
| addr | input | AW | Word address |
| wdata | input | 16 | Write data; low byte carries commands |
| rdata | output | 16 | Registered read data |
| rd_mode | output | 2 | Read source: 0 array, 1 identification, 2 status, 3 query |
| busy | output | 1 | Program or erase in progress |

## Verification
Programs are tried with fresh data, with data that would set bits on a word already programmed, and with 0xF0 as data. Together these separate a true AND from an overwrite and separate data cycles from reset commands. Unlock sequences are sent with a wrong address, a wrong first address and a stray 0xF0 in the middle, so that each one must fall back to read-array mode. A sector erase is checked against a word in a neighbouring sector. Bypass programs sent at arbitrary addresses show that the address check is skipped, and the identification and query tables are read at their defined and undefined offsets.

// File: rtl/nor_seq_pkg.sv
// Shared types and command constants for the NOR command sequencer.
// Assumes 16-bit device width; command bytes are carried in wdata[7:0].
package nor_seq_pkg;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_ID     = 2'd1,
        RM_STATUS = 2'd2,
        RM_CFI    = 2'd3
    } rd_mode_e;

    typedef enum logic [3:0] {
        SQ_READ,
        SQ_UNL1,
        SQ_CMD,
        SQ_PROG,
        SQ_EUNL0,
        SQ_EUNL1,
        SQ_ECMD,
        SQ_AUTO,
        SQ_CFI,
        SQ_BUSY
    } seq_state_e;

    localparam int          CMD_AW     = 11;
    localparam logic [10:0] ADR_UNL_A  = 11'h555;
    localparam logic [10:0] ADR_UNL_B  = 11'h2AA;
    localparam logic [10:0] ADR_QRY    = 11'h055;

    localparam logic [7:0]  K_UNL_A    = 8'hAA;
    localparam logic [7:0]  K_UNL_B    = 8'h55;
    localparam logic [7:0]  K_ERASE    = 8'h80;
    localparam logic [7:0]  K_IDENT    = 8'h90;
    localparam logic [7:0]  K_PROG     = 8'hA0;
    localparam logic [7:0]  K_BYPASS   = 8'h20;
    localparam logic [7:0]  K_CHIP     = 8'h10;
    localparam logic [7:0]  K_SECTOR   = 8'h30;
    localparam logic [7:0]  K_QUERY    = 8'h98;
    localparam logic [7:0]  K_RESET    = 8'hF0;
    localparam logic [7:0]  K_BYP_EXIT = 8'h00;

endpackage

// File: rtl/nor_cmd_fsm.sv
// Write-cycle sequencer: tracks unlock, command and argument cycles and
// issues program/erase starts. Assumes op_done is a single-cycle pulse that
// coincides with the last busy cycle of the storage engine.
module nor_cmd_fsm
    import nor_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CMD_AW-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic              op_done,
    output logic              prog_go,
    output logic              erase_go,
    output logic              erase_all,
    output rd_mode_e          mode
);

    seq_state_e state, nxt_state;
    logic       bypass, nxt_byp;
    logic       abort;
    logic       hit_a, hit_b, hit_qry;

    assign hit_a   = (cmd_addr == ADR_UNL_A);
    assign hit_b   = (cmd_addr == ADR_UNL_B);
    assign hit_qry = (cmd_addr == ADR_QRY) && (cmd_data == K_QUERY);

    // Next-state decode for one bus write, or completion of an operation.
    always_comb begin
        nxt_state = state;
        nxt_byp   = bypass;
        prog_go   = 1'b0;
        erase_go  = 1'b0;
        erase_all = 1'b0;
        abort     = 1'b0;
        if (state == SQ_BUSY) begin
            if (op_done) nxt_state = bypass ? SQ_CMD : SQ_READ;
        end else if (we) begin
            if (cmd_data == K_RESET && state != SQ_PROG) begin
                abort = 1'b1;
            end else begin
                case (state)
                    SQ_READ, SQ_EUNL0: begin
                        if (hit_qry)
                            nxt_state = SQ_CFI;
                        else if (hit_a && cmd_data == K_UNL_A)
                            nxt_state = (state == SQ_READ) ? SQ_UNL1 : SQ_EUNL1;
                        else
                            abort = 1'b1;
                    end
                    SQ_UNL1: begin
                        if (hit_b && cmd_data == K_UNL_B) nxt_state = SQ_CMD;
                        else                               abort = 1'b1;
                    end
                    SQ_EUNL1: begin
                        if (hit_b && cmd_data == K_UNL_B) nxt_state = SQ_ECMD;
                        else                               abort = 1'b1;
                    end
                    SQ_CMD: begin
                        if (!bypass && !hit_a) begin
                            abort = 1'b1;
                        end else begin
                            case (cmd_data)
                                K_BYPASS: nxt_byp   = 1'b1;
                                K_ERASE:  nxt_state = SQ_EUNL0;
                                K_IDENT:  nxt_state = SQ_AUTO;
                                K_PROG:   nxt_state = SQ_PROG;
                                default:  abort     = 1'b1;
                            endcase
                        end
                    end
                    SQ_PROG: begin
                        prog_go   = 1'b1;
                        nxt_state = SQ_BUSY;
                    end
                    SQ_ECMD: begin
                        if (cmd_data == K_CHIP && hit_a) begin
                            erase_go  = 1'b1;
                            erase_all = 1'b1;
                            nxt_state = SQ_BUSY;
                        end else if (cmd_data == K_SECTOR) begin
                            erase_go  = 1'b1;
                            nxt_state = SQ_BUSY;
                        end else begin
                            abort = 1'b1;
                        end
                    end
                    SQ_AUTO: begin
                        if (bypass && cmd_data == K_BYP_EXIT) abort = 1'b1;
                        else if (hit_qry)                     nxt_state = SQ_CFI;
                        else                                  abort = 1'b1;
                    end
                    default: abort = 1'b1;
                endcase
            end
            if (abort) begin
                nxt_state = SQ_READ;
                nxt_byp   = 1'b0;
            end
        end
    end

    // State and bypass flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SQ_READ;
            bypass <= 1'b0;
        end else begin
            state  <= nxt_state;
            bypass <= nxt_byp;
        end
    end

    // Read source select derived from the sequencer state.
    always_comb begin
        case (state)
            SQ_AUTO: mode = RM_ID;
            SQ_CFI:  mode = RM_CFI;
            SQ_BUSY: mode = RM_STATUS;
            default: mode = RM_ARRAY;
        endcase
    end

endmodule

// File: rtl/nor_store.sv
// Storage array with its program/erase engine. Program ANDs data in at once
// and then holds busy for PROG_CYCLES; erase writes ones one word per cycle.
// Assumes NSEC and SEC_WORDS are powers of two, NSEC >= 2.
module nor_store #(
    parameter int NSEC        = 4,
    parameter int SEC_WORDS   = 128,
    parameter int PROG_CYCLES = 8,
    localparam int DEPTH      = NSEC * SEC_WORDS,
    localparam int IW         = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_go,
    input  logic          erase_go,
    input  logic          erase_all,
    input  logic [IW-1:0] op_idx,
    input  logic [15:0]   prog_val,
    input  logic [IW-1:0] rd_idx,
    output logic [15:0]   rd_word,
    output logic          busy,
    output logic          done,
    output logic          stat7
);

    localparam int SW = $clog2(SEC_WORDS);
    localparam int CW = $clog2(PROG_CYCLES + 1);

    logic [15:0]   mem [DEPTH];
    logic          erasing;
    logic [IW-1:0] ptr, last_ptr;
    logic [CW-1:0] cnt;

    assign rd_word = mem[rd_idx];
    assign done    = busy && (erasing ? (ptr == last_ptr) : (cnt == '0));

    // Array contents: reset to erased, AND-in on program, ones on erase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (prog_go) begin
            mem[op_idx] <= mem[op_idx] & prog_val;
        end else if (busy && erasing) begin
            mem[ptr] <= '1;
        end
    end

    // Engine control: busy window, erase pointer and status bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            erasing  <= 1'b0;
            ptr      <= '0;
            last_ptr <= '0;
            cnt      <= '0;
            stat7    <= 1'b0;
        end else if (prog_go) begin
            busy    <= 1'b1;
            erasing <= 1'b0;
            cnt     <= CW'(PROG_CYCLES - 1);
            stat7   <= ~prog_val[7];
        end else if (erase_go) begin
            busy     <= 1'b1;
            erasing  <= 1'b1;
            stat7    <= 1'b0;
            ptr      <= erase_all ? '0 : {op_idx[IW-1:SW], {SW{1'b0}}};
            last_ptr <= erase_all ? '1 : {op_idx[IW-1:SW], {SW{1'b1}}};
        end else if (busy) begin
            if (erasing) ptr <= ptr + 1'b1;
            else         cnt <= cnt - 1'b1;
            if (done)    busy <= 1'b0;
        end
    end

endmodule

// File: rtl/nor_rd_mux.sv
// Registered read path: picks array, ID, status or query data by mode.
// Assumes the offset is the low byte of the word address.
module nor_rd_mux
    import nor_seq_pkg::*;
#(
    parameter int          NSEC      = 4,
    parameter int          SEC_WORDS = 128,
    parameter logic [15:0] MFR_ID    = 16'h0001,
    parameter logic [15:0] DEV_ID    = 16'h227E
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        re,
    input  rd_mode_e    mode,
    input  logic [7:0]  off,
    input  logic [15:0] arr_word,
    input  logic        stat7,
    output logic [15:0] rdata
);

    localparam logic [31:0] SZ_LOG = 32'($clog2(NSEC * SEC_WORDS * 2));
    localparam logic [31:0] NM1    = 32'(NSEC - 1);
    localparam logic [31:0] SEC_B  = 32'(SEC_WORDS * 2);

    logic tog;

    // Query table lookup, computed from the array geometry.
    function automatic logic [7:0] cfi_byte(input logic [7:0] o);
        case (o)
            8'h10:   return 8'h51;
            8'h11:   return 8'h52;
            8'h12:   return 8'h59;
            8'h13:   return 8'h02;
            8'h27:   return SZ_LOG[7:0];
            8'h28:   return 8'h01;
            8'h2C:   return 8'h01;
            8'h2D:   return NM1[7:0];
            8'h2E:   return NM1[15:8];
            8'h2F:   return SEC_B[15:8];
            8'h30:   return SEC_B[23:16];
            default: return 8'h00;
        endcase
    endfunction

    // Capture read data on re; status reads flip the toggle bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            tog   <= 1'b0;
        end else if (re) begin
            case (mode)
                RM_ID: begin
                    case (off)
                        8'h00:   rdata <= MFR_ID;
                        8'h01:   rdata <= DEV_ID;
                        8'h02:   rdata <= 16'h0000;
                        default: rdata <= arr_word;
                    endcase
                end
                RM_STATUS: begin
                    rdata <= {8'h00, stat7, tog, 6'h00};
                    tog   <= ~tog;
                end
                RM_CFI:  rdata <= {8'h00, cfi_byte(off)};
                default: rdata <= arr_word;
            endcase
        end
    end

endmodule

// File: rtl/nor_cmd_seq.sv
// Top of the NOR command sequencer: write-cycle FSM, storage engine and
// registered read path. Assumes AW >= 11 and a 16-bit device.
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int          AW          = 11,
    parameter int          NSEC        = 4,
    parameter int          SEC_WORDS   = 128,
    parameter int          PROG_CYCLES = 8,
    parameter logic [15:0] MFR_ID      = 16'h0001,
    parameter logic [15:0] DEV_ID      = 16'h227E
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   wdata,
    output logic [15:0]   rdata,
    output logic [1:0]    rd_mode,
    output logic          busy
);

    localparam int IW = $clog2(NSEC * SEC_WORDS);

    logic        prog_go, erase_go, erase_all, op_done, stat7;
    logic [15:0] arr_word;
    rd_mode_e    mode;

    assign rd_mode = mode;

    nor_cmd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (we),
        .cmd_addr  (addr[CMD_AW-1:0]),
        .cmd_data  (wdata[7:0]),
        .op_done   (op_done),
        .prog_go   (prog_go),
        .erase_go  (erase_go),
        .erase_all (erase_all),
        .mode      (mode)
    );

    nor_store #(
        .NSEC        (NSEC),
        .SEC_WORDS   (SEC_WORDS),
        .PROG_CYCLES (PROG_CYCLES)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_go   (prog_go),
        .erase_go  (erase_go),
        .erase_all (erase_all),
        .op_idx    (addr[IW-1:0]),
        .prog_val  (wdata),
        .rd_idx    (addr[IW-1:0]),
        .rd_word   (arr_word),
        .busy      (busy),
        .done      (op_done),
        .stat7     (stat7)
    );

    nor_rd_mux #(
        .NSEC      (NSEC),
        .SEC_WORDS (SEC_WORDS),
        .MFR_ID    (MFR_ID),
        .DEV_ID    (DEV_ID)
    ) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .re       (re),
        .mode     (mode),
        .off      (addr[7:0]),
        .arr_word (arr_word),
        .stat7    (stat7),
        .rdata    (rdata)
    );

endmodule

// File: rtl/nor_cmd_seq_chk.sv
// Property checker for nor_cmd_seq, bound to every instance of the top.
// Assumes the bound signals prog_go/erase_go are the FSM's start strobes.
module nor_cmd_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        we,
    input logic [15:0] wdata,
    input logic        busy,
    input logic [1:0]  rd_mode,
    input logic        prog_go,
    input logic        erase_go
);

    assert_status_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> rd_mode == 2'd2);

    assert_no_start_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!prog_go && !erase_go));

    assert_prog_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        prog_go |=> busy);

    assert_erase_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |=> busy);

    assert_query_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && rd_mode == 2'd3) |=> rd_mode == 2'd0);

    assert_reset_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wdata[7:0] == 8'hF0 && !busy && !prog_go) |=> (rd_mode == 2'd0 && !busy));

endmodule

bind nor_cmd_seq nor_cmd_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (we),
    .wdata    (wdata),
    .busy     (busy),
    .rd_mode  (rd_mode),
    .prog_go  (prog_go),
    .erase_go (erase_go)
);

// File: tb/nor_cmd_seq_tb.sv
module nor_cmd_seq_tb;

    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          we = 1'b0;
    logic          re = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wdata = '0;
    logic [15:0]   rdata;
    logic [1:0]    rd_mode;
    logic          busy;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;

    nor_cmd_seq u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (we),
        .re      (re),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .rd_mode (rd_mode),
        .busy    (busy)
    );

    always #4 clk = ~clk;

    // op codes: 1 write, 2 read+check, 3 wait idle, 4 unlock pair + write, 5 unlock pair
    localparam int NV = 61;
    localparam logic [55:0] VEC [NV] = '{
        {4'd2, 12'h000, 16'h0000, 16'hFFFF, 8'd1},   // R1 erased after reset
        {4'd4, 12'h555, 16'h00A0, 16'h0000, 8'd4},
        {4'd1, 12'h010, 16'h1234, 16'h0000, 8'd4},
        {4'd3, 12'h000, 16'h0000, 16'h0000, 8'd4},
        {4'd2, 12'h010, 16'h0000, 16'h1234, 8'd4},   // R4 program
        {4'd4, 12'h555, 16'h00A0, 16'h0000, 8'd4},
        {4'd1, 12'h010, 16'hFF0F, 16'h0000, 8'd4},
        {4'd3, 12'h000, 16'h0000, 16'h0000, 8'd4},
        {4'd2, 12'h010, 16'h0000, 16'h1204, 8'd4},   // R4 AND only clears bits
        {4'd4, 12'h555, 16'h00A0, 16'h0000, 8'd4},
        {4'd1, 12'h090, 16'hAAAA, 16'h0000, 8'd4},
        {4'd3, 12'h000, 16'h0000, 16'h0000, 8'd4},
        {4'd4, 12'h555, 16'h0077, 16'h0000, 8'd3},   // R3 unknown command
        {4'd1, 12'h555, 16'h00A0, 16'h0000, 8'd3},
        {4'd1, 12'h013, 16'h0000, 16'h0000, 8'd3},
        {4'd2, 12'h013, 16'h0000, 16'hFFFF, 8'd3},
        {4'd4, 12'h555, 16'h0090, 16'h0000, 8'd9},   // R9 identification
        {4'd2, 12'h000, 16'h0000, 16'h0001, 8'd9},
        {4'd2, 12'h001, 16'h0000, 16'h227E, 8'd9},
        {4'd2, 12'h002, 16'h0000, 16'h0000, 8'd9},
        {4'd2, 12'h010, 16'h0000, 16'h1204, 8'd9},
        {4'd1, 12'h055, 16'h0098, 16'h0000, 8'd10},  // R10 query from identification
        {4'd2, 12'h010, 16'h0000, 16'h0051, 8'd10},
        {4'd2, 12'h011, 16'h0000, 16'h0052, 8'd10},
        {4'd2, 12'h012, 16'h0000, 16'h0059, 8'd10},
        {4'd2, 12'h027, 16'h0000, 16'h000A, 8'd10},
        {4'd2, 12'h02D, 16'h0000, 16'h0003, 8'd10},
        {4'd2, 12'h02F, 16'h0000, 16'h0001, 8'd10},
        {4'd2, 12'h040, 16'h0000, 16'h0000, 8'd10},
        {4'd1, 12'h000, 16'h0000, 16'h0000, 8'd10},
        {4'd2, 12'h010, 16'h0000, 16'h1204, 8'd10},
        {4'd1, 12'h055, 16'h0098, 16'h0000, 8'd10},  // R10 query from read-array
        {4'd2, 12'h013, 16'h0000, 16'h0002, 8'd10},
        {4'd1, 12'h000, 16'h00F0, 16'h0000, 8'd10},
        {4'd2, 12'h013, 16'h0000, 16'hFFFF, 8'd10},
        {4'd4, 12'h555, 16'h0080, 16'h0000, 8'd5},   // R5 sector erase
        {4'd5, 12'h000, 16'h0000, 16'h0000, 8'd5},
        {4'd1, 12'h005, 16'h0030, 16'h0000, 8'd5},
        {4'd3, 12'h000, 16'h0000, 16'h0000, 8'd5},
        {4'd2, 12'h010, 16'h0000, 16'hFFFF, 8'd5},
        {4'd2, 12'h090, 16'h0000, 16'hAAAA, 8'd5},
        {4'd4, 12'h555, 16'h0020, 16'h0000, 8'd7},   // R7 bypass
        {4'd1, 12'h123, 16'h00A0, 16'h0000, 8'd7},
        {4'd1, 12'h091, 16'h5555, 16'h0000, 8'd7},
        {4'd3, 12'h000, 16'h0000, 16'h0000, 8'd7},
        {4'd2, 12'h091, 16'h0000, 16'h5555, 8'd7},
        {4'd1, 12'h000, 16'h00A0, 16'h0000, 8'd7},
        {4'd1, 12'h092, 16'h0F0F, 16'h0000, 8'd7},
        {4'd3, 12'h000, 16'h0000, 16'h0000, 8'd7},
        {4'd2, 12'h092, 16'h0000, 16'h0F0F, 8'd7},
        {4'd1, 12'h000, 16'h0090, 16'h0000, 8'd7},
        {4'd2, 12'h001, 16'h0000, 16'h227E, 8'd7},
        {4'd1, 12'h000, 16'h0000, 16'h0000, 8'd7},
        {4'd1, 12'h000, 16'h00A0, 16'h0000, 8'd7},
        {4'd1, 12'h093, 16'h0000, 16'h0000, 8'd7},
        {4'd2, 12'h093, 16'h0000, 16'hFFFF, 8'd7},
        {4'd4, 12'h555, 16'h0080, 16'h0000, 8'd6},   // R6 chip erase
        {4'd4, 12'h555, 16'h0010, 16'h0000, 8'd6},
        {4'd3, 12'h000, 16'h0000, 16'h0000, 8'd6},
        {4'd2, 12'h090, 16'h0000, 16'hFFFF, 8'd6},
        {4'd2, 12'h092, 16'h0000, 16'hFFFF, 8'd6}
    };

    task automatic check(input int req, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL R%0d: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        we = 1'b1; addr = a[AW-1:0]; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [15:0] d);
        @(negedge clk);
        re = 1'b1; addr = a[AW-1:0];
        @(negedge clk);
        re = 1'b0;
        d = rdata;
    endtask

    task automatic unlock();
        wr(12'h555, 16'h00AA);
        wr(12'h2AA, 16'h0055);
    endtask

    task automatic wait_idle(input int req);
        int n = 0;
        while (busy === 1'b1 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(req, {15'd0, busy}, 16'h0000);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_errors++;
            $display("FAIL R0: watchdog actual %0d expected below 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(1, {14'd0, rd_mode}, 16'd0);  // R1 reset mode
        check(1, {15'd0, busy}, 16'd0);     // R1 reset busy

        for (int i = 0; i < NV; i++) begin
            case (VEC[i][55:52])
                4'd1: wr(VEC[i][51:40], VEC[i][39:24]);
                4'd2: begin
                    rd(VEC[i][51:40], d);
                    check(int'(VEC[i][7:0]), d, VEC[i][23:8]);
                end
                4'd3: wait_idle(int'(VEC[i][7:0]));
                4'd4: begin
                    unlock();
                    wr(VEC[i][51:40], VEC[i][39:24]);
                end
                4'd5: unlock();
                default: ;
            endcase
        end

        // R11 status and ignored writes during program
        unlock(); wr(12'h555, 16'h00A0); wr(12'h095, 16'h0000);
        check(11, {15'd0, busy}, 16'd1);
        check(11, {14'd0, rd_mode}, 16'd2);
        rd(12'h000, d); check(11, d, 16'h0080);
        rd(12'h000, d); check(11, d, 16'h00C0);
        wr(12'h000, 16'h00F0);
        rd(12'h000, d); check(11, d, 16'h0080);
        wait_idle(11);
        check(11, {14'd0, rd_mode}, 16'd0);
        rd(12'h095, d); check(4, d, 16'h0000);

        // R5 erase status bit 7 is 0, toggle continues
        unlock(); wr(12'h555, 16'h0080); unlock(); wr(12'h100, 16'h0030);
        rd(12'h000, d); check(5, d, 16'h0040);
        rd(12'h000, d); check(5, d, 16'h0000);
        wait_idle(5);
        rd(12'h095, d); check(5, d, 16'h0000);

        // R8 0xF0 as program data
        unlock(); wr(12'h555, 16'h00A0); wr(12'h0A0, 16'h00F0);
        wait_idle(8);
        rd(12'h0A0, d); check(8, d, 16'h00F0);

        // R8 0xF0 aborts a sequence
        unlock(); wr(12'h123, 16'h00F0); wr(12'h555, 16'h00A0); wr(12'h0A1, 16'h0000);
        rd(12'h0A1, d); check(8, d, 16'hFFFF);

        // R2 wrong second-cycle address, then wrong first-cycle address
        wr(12'h555, 16'h00AA); wr(12'h2AB, 16'h0055); wr(12'h555, 16'h00A0); wr(12'h0A2, 16'h0000);
        rd(12'h0A2, d); check(2, d, 16'hFFFF);
        wr(12'h554, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h555, 16'h00A0); wr(12'h0A3, 16'h0000);
        rd(12'h0A3, d); check(2, d, 16'hFFFF);

        // R12 registered read latency and hold
        @(negedge clk); re = 1'b1; addr = 11'h0A0;
        #1 check(12, rdata, 16'hFFFF);
        @(negedge clk); re = 1'b0; addr = 11'h0A2;
        check(12, rdata, 16'h00F0);
        @(negedge clk);
        check(12, rdata, 16'h00F0);

        // R9 / R10 mode select values
        unlock(); wr(12'h555, 16'h0090);
        check(9, {14'd0, rd_mode}, 16'd1);
        wr(12'h055, 16'h0098);
        check(10, {14'd0, rd_mode}, 16'd3);

        // R1 reset mid-sequence
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check(1, {14'd0, rd_mode}, 16'd0);
        check(1, {15'd0, busy}, 16'd0);
        rd(12'h0A0, d); check(1, d, 16'hFFFF);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule